// File: doc/BRIEF.md
# Privileged Status Write Filter

This block holds the privileged control state of a processor hart: the machine status word, the machine interrupt-pending, interrupt-enable and interrupt-delegation words, two counter-enable words and two trap-vector bases. Every write is filtered field by field before it lands. Bits that may not change keep their value. A memory-translation mode or a previous-privilege value that is not legal leaves its old value in place. The status word carries a summary-dirty flag that is derived from the floating-point and extension state fields.

The supervisor status, pending and enable addresses have no storage of their own. They are windows onto the machine registers through fixed or delegation-controlled masks, and a write through them changes only the bits the window exposes. Access is a plain register port: a 12-bit address, write data and a write strobe. Read data and an unmapped-address flag are combinational from the address. A write takes effect at the rising clock edge, so the next cycle reads the new value. Because the port is a register-file access and not a data stream, there is no back-pressure.

Top module: `priv_status_filter`

## Requirements
- R1: After reset every register reads zero, except the machine trap vector (address 0x305), which reads the parameter MTVEC_RESET with bits 1:0 cleared.
- R2: A status write (address 0x300) changes only bits 1, 3, 5, 7, 8, 13 to 14, 17 and 18. Bits 16:15 change only when HAS_EXT is 1. Every other bit outside the mode and previous-privilege fields reads zero.
- R3: The status memory-mode field, bits 28:24, takes the written value only if that value is legal: 0 for either width, 9 or 10 when XLEN is 64, or 8 when XLEN is 32. Any other value leaves the field unchanged.
- R4: The status previous-privilege field, bits 12:11, takes the written value only if it is 0, 1 or 3. The value 2 leaves the field unchanged.
- R5: Status bit XLEN-1 reads 1 exactly when bits 14:13 are both 1 or bits 16:15 are both 1.
- R6: A write to the machine pending word (0x344) can change only bits 1 and 5.
- R7: The machine enable word (0x304) keeps only bits 1, 3, 5, 7, 9 and 12. The delegation word (0x303) keeps only bits 1, 5, 9 and 12.
- R8: The supervisor pending (0x144) and enable (0x104) addresses read the machine word ANDed with the delegation word. A write through them changes only bits that are set in the delegation word, and is still subject to the R6 and R7 masks.
- R9: The supervisor status address (0x100) reads bits 1, 5, 8, 13 to 16 and 18 of the status word, plus bit XLEN-1 recomputed per R5. A write through it changes only those bits.
- R10: Both trap-vector addresses (0x305 and 0x105) store the written value with bits 1:0 cleared.
- R11: The user counter-enable word (0x320) and the supervisor counter-enable word (0x321) keep only bits 2:0.
- R12: An address outside the mapped set reads zero and raises csr_addr_bad, and a write to it changes nothing. Mapped addresses keep csr_addr_bad low.
- R13: No register changes in a cycle where csr_we is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| csr_we | input | 1 | Write strobe; the write lands at the next rising edge |
| csr_rdata | output | XLEN | Read data for csr_addr, combinational |
| csr_addr_bad | output | 1 | High when csr_addr is not a mapped register |

## Verification
The bound checker watches the stored state on every cycle. The delegation and pending words must never hold an unwritable bit, the previous-privilege and memory-mode fields must always hold legal encodings, and the dirty summary must agree with its source fields. It also checks that nothing moves without a write strobe or on an unmapped write, that unmapped reads return zero, and that vector reads are aligned. Only the bench scenarios show which exact bits a given write keeps and that an illegal mode or privilege value preserves the earlier one. They also show how the supervisor windows track the delegation word as it changes, and the reset values.

// File: rtl/psf_pkg.sv
package psf_pkg;

  localparam int unsigned ADDR_W = 12;

  // Register addresses (software-visible encoding)
  localparam logic [ADDR_W-1:0] A_SSTATUS = 12'h100;
  localparam logic [ADDR_W-1:0] A_SIE     = 12'h104;
  localparam logic [ADDR_W-1:0] A_STVEC   = 12'h105;
  localparam logic [ADDR_W-1:0] A_SIP     = 12'h144;
  localparam logic [ADDR_W-1:0] A_MSTATUS = 12'h300;
  localparam logic [ADDR_W-1:0] A_MIDELEG = 12'h303;
  localparam logic [ADDR_W-1:0] A_MIE     = 12'h304;
  localparam logic [ADDR_W-1:0] A_MTVEC   = 12'h305;
  localparam logic [ADDR_W-1:0] A_UCNTEN  = 12'h320;
  localparam logic [ADDR_W-1:0] A_SCNTEN  = 12'h321;
  localparam logic [ADDR_W-1:0] A_MIP     = 12'h344;

  // Status word field positions
  localparam int B_SIE   = 1;
  localparam int B_MIE   = 3;
  localparam int B_SPIE  = 5;
  localparam int B_MPIE  = 7;
  localparam int B_SPP   = 8;
  localparam int B_MPP   = 11;  // 2 bits
  localparam int B_FS    = 13;  // 2 bits
  localparam int B_XS    = 15;  // 2 bits
  localparam int B_MPRV  = 17;
  localparam int B_PUM   = 18;
  localparam int B_VM    = 24;  // 5 bits
  localparam int VM_W    = 5;

  // Memory-mode encodings
  localparam logic [VM_W-1:0] VM_BARE = 5'd0;
  localparam logic [VM_W-1:0] VM_PG32 = 5'd8;
  localparam logic [VM_W-1:0] VM_PG39 = 5'd9;
  localparam logic [VM_W-1:0] VM_PG48 = 5'd10;

  // Interrupt bit positions
  localparam int I_SSW  = 1;
  localparam int I_MSW  = 3;
  localparam int I_STM  = 5;
  localparam int I_MTM  = 7;
  localparam int I_SEXT = 9;
  localparam int I_COP  = 12;

  localparam int CNTEN_W = 3;
  localparam int N_VEC   = 2;   // index 0: machine, 1: supervisor

  typedef struct packed {
    logic mstatus;
    logic sstatus;
    logic mip;
    logic sip;
    logic mie;
    logic sie;
    logic mideleg;
    logic mtvec;
    logic stvec;
    logic ucnten;
    logic scnten;
  } psf_sel_t;

endpackage

// File: rtl/psf_decode.sv
module psf_decode
  import psf_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output psf_sel_t          sel,
  output logic              bad
);

  always_comb begin
    sel         = '0;
    sel.mstatus = (addr == A_MSTATUS);
    sel.sstatus = (addr == A_SSTATUS);
    sel.mip     = (addr == A_MIP);
    sel.sip     = (addr == A_SIP);
    sel.mie     = (addr == A_MIE);
    sel.sie     = (addr == A_SIE);
    sel.mideleg = (addr == A_MIDELEG);
    sel.mtvec   = (addr == A_MTVEC);
    sel.stvec   = (addr == A_STVEC);
    sel.ucnten  = (addr == A_UCNTEN);
    sel.scnten  = (addr == A_SCNTEN);
  end

  assign bad = (sel == '0);

endmodule

// File: rtl/psf_status.sv
module psf_status
  import psf_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter bit          HAS_EXT = 1'b1
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_val,
  output logic [XLEN-1:0] status_q
);

  localparam logic [XLEN-1:0] ONE      = {{(XLEN-1){1'b0}}, 1'b1};
  localparam logic [XLEN-1:0] M_FS     = (ONE << B_FS) | (ONE << (B_FS + 1));
  localparam logic [XLEN-1:0] M_XS     = (ONE << B_XS) | (ONE << (B_XS + 1));
  localparam logic [XLEN-1:0] M_MPP    = (ONE << B_MPP) | (ONE << (B_MPP + 1));
  localparam logic [XLEN-1:0] M_VM     = ((ONE << VM_W) - ONE) << B_VM;
  localparam logic [XLEN-1:0] M_SD     = ONE << (XLEN - 1);
  localparam logic [XLEN-1:0] M_FIXED  = (ONE << B_SIE) | (ONE << B_MIE) |
                                         (ONE << B_SPIE) | (ONE << B_MPIE) |
                                         (ONE << B_SPP) | M_FS |
                                         (ONE << B_MPRV) | (ONE << B_PUM) |
                                         (HAS_EXT ? M_XS : '0);

  logic [VM_W-1:0] vm_new;
  logic [1:0]      mpp_new;
  logic            vm_legal;
  logic            mpp_legal;
  logic [XLEN-1:0] wmask;
  logic [XLEN-1:0] merged;
  logic            dirty;
  logic [XLEN-1:0] status_d;

  assign vm_new  = wr_val[B_VM +: VM_W];
  assign mpp_new = wr_val[B_MPP +: 2];

  generate
    if (XLEN == 64) begin : g_vm64
      assign vm_legal = (vm_new == VM_BARE) || (vm_new == VM_PG39) ||
                        (vm_new == VM_PG48);
    end else begin : g_vm32
      assign vm_legal = (vm_new == VM_BARE) || (vm_new == VM_PG32);
    end
  endgenerate

  assign mpp_legal = (mpp_new != 2'b10);

  always_comb begin
    wmask    = M_FIXED | (vm_legal ? M_VM : '0) | (mpp_legal ? M_MPP : '0);
    merged   = (status_q & ~wmask) | (wr_val & wmask);
    dirty    = (&merged[B_FS +: 2]) | (&merged[B_XS +: 2]);
    status_d = (merged & ~M_SD) | (dirty ? M_SD : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     status_q <= '0;
    else if (wr_en) status_q <= status_d;
  end

endmodule

// File: rtl/psf_irq.sv
module psf_irq
  import psf_pkg::*;
#(
  parameter int unsigned XLEN = 64
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mip_we,
  input  logic            sip_we,
  input  logic            mie_we,
  input  logic            sie_we,
  input  logic            deleg_we,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] mip_q,
  output logic [XLEN-1:0] mie_q,
  output logic [XLEN-1:0] deleg_q
);

  localparam logic [XLEN-1:0] ONE     = {{(XLEN-1){1'b0}}, 1'b1};
  localparam logic [XLEN-1:0] M_DELEG = (ONE << I_SSW) | (ONE << I_STM) |
                                        (ONE << I_SEXT) | (ONE << I_COP);
  localparam logic [XLEN-1:0] M_ALL   = M_DELEG | (ONE << I_MSW) | (ONE << I_MTM);
  localparam logic [XLEN-1:0] M_PEND  = (ONE << I_SSW) | (ONE << I_STM);

  logic [XLEN-1:0] pend_src, en_src;
  logic [XLEN-1:0] pend_d, en_d, deleg_d;

  always_comb begin
    // supervisor windows merge only the delegated bits into the machine word
    pend_src = sip_we ? ((mip_q & ~deleg_q) | (wdata & deleg_q)) : wdata;
    en_src   = sie_we ? ((mie_q & ~deleg_q) | (wdata & deleg_q)) : wdata;
    pend_d   = (mip_q & ~M_PEND) | (pend_src & M_PEND);
    en_d     = (mie_q & ~M_ALL) | (en_src & M_ALL);
    deleg_d  = (deleg_q & ~M_DELEG) | (wdata & M_DELEG);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mip_q   <= '0;
      mie_q   <= '0;
      deleg_q <= '0;
    end else begin
      if (mip_we || sip_we) mip_q   <= pend_d;
      if (mie_we || sie_we) mie_q   <= en_d;
      if (deleg_we)         deleg_q <= deleg_d;
    end
  end

endmodule

// File: rtl/psf_trapcfg.sv
module psf_trapcfg
  import psf_pkg::*;
#(
  parameter int unsigned     XLEN        = 64,
  parameter logic [XLEN-1:0] MTVEC_RESET = 'h100
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_VEC-1:0]            vec_we,
  input  logic [1:0]                  cnt_we,
  input  logic [XLEN-1:0]             wdata,
  output logic [N_VEC-1:0][XLEN-1:0]  vec_q,
  output logic [1:0][CNTEN_W-1:0]     cnt_q
);

  localparam logic [XLEN-1:0] ALIGN = ~{{(XLEN-2){1'b0}}, 2'b11};

  generate
    for (genvar g = 0; g < N_VEC; g++) begin : g_vec
      localparam logic [XLEN-1:0] RST = (g == 0) ? (MTVEC_RESET & ALIGN) : '0;
      always_ff @(posedge clk) begin
        if (!rst_n)        vec_q[g] <= RST;
        else if (vec_we[g]) vec_q[g] <= wdata & ALIGN;
      end
    end

    for (genvar c = 0; c < 2; c++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q[c] <= '0;
        else if (cnt_we[c]) cnt_q[c] <= wdata[CNTEN_W-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/priv_status_filter.sv
module priv_status_filter
  import psf_pkg::*;
#(
  parameter int unsigned     XLEN        = 64,
  parameter bit              HAS_EXT     = 1'b1,
  parameter logic [XLEN-1:0] MTVEC_RESET = 'h100
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic              csr_we,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_addr_bad
);

  localparam logic [XLEN-1:0] ONE    = {{(XLEN-1){1'b0}}, 1'b1};
  localparam logic [XLEN-1:0] M_SVIS = (ONE << B_SIE) | (ONE << B_SPIE) |
                                       (ONE << B_SPP) |
                                       (ONE << B_FS) | (ONE << (B_FS + 1)) |
                                       (ONE << B_XS) | (ONE << (B_XS + 1)) |
                                       (ONE << B_PUM);
  localparam logic [XLEN-1:0] M_SD   = ONE << (XLEN - 1);

  psf_sel_t        sel;
  logic            bad;
  logic            wr;
  logic [XLEN-1:0] st_q;
  logic [XLEN-1:0] st_wval;
  logic [XLEN-1:0] mip_q, mie_q, mideleg_q;
  logic [N_VEC-1:0][XLEN-1:0]    vec_q;
  logic [1:0][CNTEN_W-1:0]       cnt_q;
  logic            sv_dirty;
  logic [XLEN-1:0] sstatus_view;

  psf_decode u_dec (
    .addr (csr_addr),
    .sel  (sel),
    .bad  (bad)
  );

  assign wr = csr_we && !bad;

  // supervisor status writes are folded into a full status write
  assign st_wval = sel.sstatus ? ((st_q & ~M_SVIS) | (csr_wdata & M_SVIS))
                               : csr_wdata;

  psf_status #(.XLEN(XLEN), .HAS_EXT(HAS_EXT)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr && (sel.mstatus || sel.sstatus)),
    .wr_val   (st_wval),
    .status_q (st_q)
  );

  psf_irq #(.XLEN(XLEN)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mip_we   (wr && sel.mip),
    .sip_we   (wr && sel.sip),
    .mie_we   (wr && sel.mie),
    .sie_we   (wr && sel.sie),
    .deleg_we (wr && sel.mideleg),
    .wdata    (csr_wdata),
    .mip_q    (mip_q),
    .mie_q    (mie_q),
    .deleg_q  (mideleg_q)
  );

  psf_trapcfg #(.XLEN(XLEN), .MTVEC_RESET(MTVEC_RESET)) u_trap (
    .clk    (clk),
    .rst_n  (rst_n),
    .vec_we ({wr && sel.stvec, wr && sel.mtvec}),
    .cnt_we ({wr && sel.scnten, wr && sel.ucnten}),
    .wdata  (csr_wdata),
    .vec_q  (vec_q),
    .cnt_q  (cnt_q)
  );

  assign sv_dirty     = (&st_q[B_FS +: 2]) | (&st_q[B_XS +: 2]);
  assign sstatus_view = (st_q & M_SVIS) | (sv_dirty ? M_SD : '0);

  // one-hot select, AND-OR read mux
  always_comb begin
    csr_rdata = ({XLEN{sel.mstatus}} & st_q)
              | ({XLEN{sel.sstatus}} & sstatus_view)
              | ({XLEN{sel.mip}}     & mip_q)
              | ({XLEN{sel.sip}}     & (mip_q & mideleg_q))
              | ({XLEN{sel.mie}}     & mie_q)
              | ({XLEN{sel.sie}}     & (mie_q & mideleg_q))
              | ({XLEN{sel.mideleg}} & mideleg_q)
              | ({XLEN{sel.mtvec}}   & vec_q[0])
              | ({XLEN{sel.stvec}}   & vec_q[1])
              | ({XLEN{sel.ucnten}}  & {{(XLEN-CNTEN_W){1'b0}}, cnt_q[0]})
              | ({XLEN{sel.scnten}}  & {{(XLEN-CNTEN_W){1'b0}}, cnt_q[1]});
  end

  assign csr_addr_bad = bad;

endmodule

// File: rtl/psf_checker.sv
module psf_checker
  import psf_pkg::*;
#(
  parameter int unsigned XLEN = 64
)(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] csr_addr,
  input logic              csr_we,
  input logic [XLEN-1:0]   csr_rdata,
  input logic              csr_addr_bad,
  input logic [XLEN-1:0]   st_q,
  input logic [XLEN-1:0]   mip_q,
  input logic [XLEN-1:0]   mideleg_q
);

  localparam logic [XLEN-1:0] ONE    = {{(XLEN-1){1'b0}}, 1'b1};
  localparam logic [XLEN-1:0] OK_DLG = (ONE << I_SSW) | (ONE << I_STM) |
                                       (ONE << I_SEXT) | (ONE << I_COP);
  localparam logic [XLEN-1:0] OK_PND = (ONE << I_SSW) | (ONE << I_STM);

  logic [VM_W-1:0] vm_f;
  assign vm_f = st_q[B_VM +: VM_W];

  p_vm_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vm_f == VM_BARE) ||
    ((XLEN == 64) ? (vm_f == VM_PG39 || vm_f == VM_PG48) : (vm_f == VM_PG32)));

  p_mpp_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[B_MPP +: 2] != 2'b10);

  p_dirty_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[XLEN-1] == ((&st_q[B_FS +: 2]) || (&st_q[B_XS +: 2])));

  p_pend_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mip_q & ~OK_PND) == '0);

  p_deleg_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mideleg_q & ~OK_DLG) == '0);

  p_vec_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == A_MTVEC || csr_addr == A_STVEC) |-> csr_rdata[1:0] == 2'b00);

  p_bad_reads_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    csr_addr_bad |-> csr_rdata == '0);

  p_bad_write_inert_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr_bad) |=> ($stable(st_q) && $stable(mip_q) && $stable(mideleg_q)));

  p_no_strobe_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |=> ($stable(st_q) && $stable(mip_q) && $stable(mideleg_q)));

endmodule

bind priv_status_filter psf_checker #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .csr_addr     (csr_addr),
  .csr_we       (csr_we),
  .csr_rdata    (csr_rdata),
  .csr_addr_bad (csr_addr_bad),
  .st_q         (st_q),
  .mip_q        (mip_q),
  .mideleg_q    (mideleg_q)
);

// File: tb/priv_status_filter_tb.sv
`timescale 1ns/1ps
module priv_status_filter_tb;

  localparam int XL = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   csr_addr = '0;
  logic [XL-1:0] csr_wdata = '0;
  logic          csr_we = 1'b0;
  logic [XL-1:0] csr_rdata;
  logic          csr_addr_bad;

  priv_status_filter #(.XLEN(XL), .HAS_EXT(1'b1), .MTVEC_RESET(64'h100)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .csr_addr     (csr_addr),
    .csr_wdata    (csr_wdata),
    .csr_we       (csr_we),
    .csr_rdata    (csr_rdata),
    .csr_addr_bad (csr_addr_bad)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [XL-1:0] data;
    logic          bad;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  logic rd_now = 1'b0;
  bit   done   = 1'b0;

  localparam logic [XL-1:0] ALL1 = '1;
  localparam logic [XL-1:0] SD   = 64'h8000_0000_0000_0000;

  // monitor: compares mid-cycle, away from the active edge
  always @(negedge clk) begin
    if (rd_now && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (csr_rdata !== e.data || csr_addr_bad !== e.bad) begin
        fails++;
        $display("FAIL %s: rdata=%h bad=%b expected rdata=%h bad=%b",
                 e.tag, csr_rdata, csr_addr_bad, e.data, e.bad);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [XL-1:0] d);
    @(posedge clk); #1;
    rd_now = 1'b0; csr_addr = a; csr_wdata = d; csr_we = 1'b1;
  endtask

  task automatic rd(input logic [11:0] a, input logic [XL-1:0] exp_d,
                    input logic exp_bad, input string tag);
    exp_t e;
    @(posedge clk); #1;
    csr_we = 1'b0; csr_addr = a; csr_wdata = '0;
    e.data = exp_d; e.bad = exp_bad; e.tag = tag;
    q.push_back(e);
    rd_now = 1'b1;
  endtask

  task automatic idle(input logic [11:0] a, input logic [XL-1:0] d);
    @(posedge clk); #1;
    rd_now = 1'b0; csr_we = 1'b0; csr_addr = a; csr_wdata = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    rd(12'h300, '0, 1'b0, "R1 mstatus reset");
    rd(12'h344, '0, 1'b0, "R1 mip reset");
    rd(12'h304, '0, 1'b0, "R1 mie reset");
    rd(12'h303, '0, 1'b0, "R1 mideleg reset");
    rd(12'h305, 64'h100, 1'b0, "R1 mtvec reset");
    rd(12'h105, '0, 1'b0, "R1 stvec reset");
    rd(12'h320, '0, 1'b0, "R1 ucnten reset");

    // R2 R3 R4 R5: all-ones status write, illegal mode 0x1F kept at 0
    wr(12'h300, ALL1);
    rd(12'h300, SD | 64'h7F9AA, 1'b0, "R2 R3 R5 mstatus all ones");
    // R3 mode 9 legal; R4 mpp=2 rejected, keeps 3; FS=1 not dirty
    wr(12'h300, 64'h0900_3000);
    rd(12'h300, 64'h0900_3800, 1'b0, "R3 R4 legal mode, illegal mpp");
    // R3 mode 8 illegal at 64 bits, mode stays 9; mpp=0 accepted
    wr(12'h300, 64'h0800_0000);
    rd(12'h300, 64'h0900_0000, 1'b0, "R3 32-bit mode rejected");
    // R5 dirty through XS
    wr(12'h300, 64'h0001_8000);
    rd(12'h300, SD | 64'h0001_8000, 1'b0, "R5 dirty from XS");
    // R2 unwritable bits ignored
    wr(12'h300, 64'h0010_0014);
    rd(12'h300, '0, 1'b0, "R2 unwritable bits");

    // R9 supervisor status window
    wr(12'h300, 64'h1888);
    wr(12'h100, ALL1);
    rd(12'h100, SD | 64'h5E122, 1'b0, "R9 sstatus view");
    rd(12'h300, SD | 64'h5F9AA, 1'b0, "R9 mstatus after sstatus write");
    wr(12'h100, '0);
    rd(12'h300, 64'h1888, 1'b0, "R9 machine fields kept");
    rd(12'h100, '0, 1'b0, "R9 sstatus cleared");

    // R6 R7
    wr(12'h344, ALL1);
    rd(12'h344, 64'h22, 1'b0, "R6 mip mask");
    wr(12'h304, ALL1);
    rd(12'h304, 64'h12AA, 1'b0, "R7 mie mask");
    wr(12'h303, ALL1);
    rd(12'h303, 64'h1222, 1'b0, "R7 mideleg mask");

    // R8 supervisor windows
    rd(12'h144, 64'h22, 1'b0, "R8 sip view");
    rd(12'h104, 64'h1222, 1'b0, "R8 sie view");
    wr(12'h303, 64'h2);
    wr(12'h144, '0);
    rd(12'h344, 64'h20, 1'b0, "R8 sip write only delegated bit");
    wr(12'h104, '0);
    rd(12'h304, 64'h12A8, 1'b0, "R8 sie write only delegated bit");
    wr(12'h344, '0);
    wr(12'h303, 64'h20);
    wr(12'h144, ALL1);
    rd(12'h344, 64'h20, 1'b0, "R8 sip set delegated bit");
    rd(12'h144, 64'h20, 1'b0, "R8 sip view after set");

    // R10 vectors
    wr(12'h305, 64'h1237);
    rd(12'h305, 64'h1234, 1'b0, "R10 mtvec align");
    wr(12'h105, ALL1);
    rd(12'h105, ALL1 & ~64'h3, 1'b0, "R10 stvec align");

    // R11 counter enables
    wr(12'h320, 64'hFF);
    rd(12'h320, 64'h7, 1'b0, "R11 ucnten");
    wr(12'h321, 64'hA);
    rd(12'h321, 64'h2, 1'b0, "R11 scnten");

    // R12 unmapped
    rd(12'h7C0, '0, 1'b1, "R12 unmapped read");
    wr(12'h7C0, ALL1);
    rd(12'h7C0, '0, 1'b1, "R12 unmapped after write");
    rd(12'h305, 64'h1234, 1'b0, "R12 mtvec untouched");

    // R13 no strobe, no change
    idle(12'h305, 64'hDEAD_BEEF);
    idle(12'h300, ALL1);
    rd(12'h305, 64'h1234, 1'b0, "R13 mtvec held");
    rd(12'h300, 64'h1888, 1'b0, "R13 mstatus held");

    idle(12'h000, '0);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule